// File: doc/BRIEF.md
# Edge-Triggered Interrupt Acceptance Unit

This unit watches two external interrupt request pins, turns a chosen transition on each into a latched request, and tells the processor core when it may take one. Each pin is first brought into the core clock domain through a short flop chain. The pin's present level is compared with the level one cycle earlier. When the direction selected for that pin (rising or falling) appears, the pin's pending latch is set. Several sources wired together onto one pin produce one transition, and so they leave a single request. Further edges that arrive while a request is already pending add nothing.

Pending requests are offered to the core only when the core signals that an instruction has completed. If that instruction carries the privileged marker, nothing is offered at its end. The offer waits until a non-privileged instruction completes, so a stack-pointer load and the segment write that follows it run with no interrupt between them. Stack-pointer loads from the index and HL registers are examples that must raise the marker. A global enable gates the offer without stopping the latching. When both lines are pending, line 0 is offered first. The core clears each latch with a per-line acknowledge. The synchronized pin levels also appear at fixed bits of a parallel-port read word, whatever the interrupt settings.

Top module: `irq_accept_unit`

## Requirements
- R1: The design latches a request in the third clock edge after a pin change. The pin change must match the direction programmed for that line. With the default two-stage synchronizer, the request can be taken at any completion strobe from that point on.
- R2: A transition opposite to the programmed direction latches nothing. The direction bit is 1 for rising and 0 for falling.
- R3: The port read word `port_rd_o` holds the synchronized level of line i at bit IRQ_BIT_LO+i (bits 4 and 5 by default). It shows this level whatever the edge selection and the enable. The other bits carry `port_data_i` in order, below and above that field.
- R4: Any number of matching edges while a line is pending leave one request. After one acknowledge, nothing more is offered.
- R5: `take_o` is high only in a cycle where all of the following hold: `instr_done_i` is high, `instr_priv_i` is low, the enable is high and at least one line is pending.
- R6: A completion marked privileged never produces `take_o`. A run of privileged completions keeps deferring the offer, and the next non-privileged completion takes the request.
- R7: An acknowledge clears that line's latch at the next edge. A matching edge detected in the same cycle as the acknowledge wins, and the latch stays set.
- R8: With both lines pending, `take_line_o` is 0. Line 1 stays pending and is offered at a later boundary once line 0 has been acknowledged.
- R9: With `irq_en_i` low, no request is taken, but edges are still latched. The request is taken once the enable returns.
- R10: Reset clears both pending latches and the synchronizer state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_pin_i | input | NUM_LINES | Raw external request pins |
| edge_rise_i | input | NUM_LINES | Per-line direction: 1 rising, 0 falling |
| irq_en_i | input | 1 | Global interrupt enable |
| port_data_i | input | PORT_W-NUM_LINES | Other parallel-port input bits |
| port_rd_o | output | PORT_W | Parallel-port read word including pin levels |
| instr_done_i | input | 1 | Instruction-completed strobe from the core |
| instr_priv_i | input | 1 | Completing instruction is privileged |
| ack_i | input | NUM_LINES | Per-line acknowledge, clears the latch |
| take_o | output | 1 | Core may take an interrupt now |
| take_line_o | output | LINE_W | Line being offered |

## Verification
The bench builds the unit with its default parameters: two lines, a two-stage synchronizer, an 8-bit port word and the pin field at bit 4. With these values the three-edge latency from pin to latch is fixed. The bench can therefore time an acknowledge to land in exactly the cycle in which a new edge is detected. The port field sits in the middle of the word, so the pass-through on both sides of it is observable. Two lines are enough to exercise the fixed priority and the holding of the lower-priority request across boundaries.

// File: rtl/irq_acc_pkg.sv
package irq_acc_pkg;

    typedef enum logic {
        EDGE_FALL = 1'b0,
        EDGE_RISE = 1'b1
    } edge_pol_e;

    // True when the sampled transition matches the selected direction.
    function automatic logic edge_match(input edge_pol_e pol,
                                        input logic      lvl_now,
                                        input logic      lvl_old);
        logic hit;
        if (pol == EDGE_RISE) hit = lvl_now & ~lvl_old;
        else                  hit = ~lvl_now & lvl_old;
        return hit;
    endfunction

endpackage

// File: rtl/irq_line_detect.sv
module irq_line_detect
    import irq_acc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic rise_sel_i,
    input  logic ack_i,
    output logic level_o,
    output logic pend_o
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
        logic                   pend;
    } line_st_t;

    line_st_t  st_q, st_d;
    edge_pol_e pol;
    logic      lvl;
    logic      hit;

    assign pol = edge_pol_e'(rise_sel_i);
    assign lvl = st_q.sync[SYNC_STAGES-1];
    assign hit = edge_match(pol, lvl, st_q.prev);

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], pin_i};
        st_d.prev = lvl;
        // a fresh edge overrides a simultaneous acknowledge
        if (hit)        st_d.pend = 1'b1;
        else if (ack_i) st_d.pend = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level_o = lvl;
    assign pend_o  = st_q.pend;

    assert_edge_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> pend_o);

    assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && ack_i && !hit) |=> !pend_o);

    assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend_o && !hit) |=> !pend_o);

endmodule

// File: rtl/irq_accept_arb.sv
module irq_accept_arb #(
    parameter int NUM_LINES = 2,
    parameter int LINE_W    = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] pend_i,
    input  logic                 en_i,
    input  logic                 done_i,
    input  logic                 priv_i,
    output logic                 take_o,
    output logic [LINE_W-1:0]    line_o
);

    logic boundary_ok;

    // acceptance only at a non-privileged completion
    assign boundary_ok = done_i & ~priv_i;
    assign take_o      = boundary_ok & en_i & (|pend_i);

    always_comb begin
        line_o = '0;
        for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (pend_i[i]) line_o = LINE_W'(i);
        end
    end

    assert_take_at_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (done_i && !priv_i && en_i));

    assert_priv_defers_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && priv_i) |-> !take_o);

    assert_enable_gates_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |-> !take_o);

    assert_line_zero_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && pend_i[0]) |-> (line_o == '0));

endmodule

// File: rtl/irq_port_merge.sv
module irq_port_merge #(
    parameter int NUM_LINES  = 2,
    parameter int PORT_W     = 8,
    parameter int IRQ_BIT_LO = 4
) (
    input  logic [NUM_LINES-1:0]        lvl_i,
    input  logic [PORT_W-NUM_LINES-1:0] data_i,
    output logic [PORT_W-1:0]           rd_o
);

    for (genvar b = 0; b < PORT_W; b++) begin : g_bit
        if (b >= IRQ_BIT_LO && b < IRQ_BIT_LO + NUM_LINES) begin : g_irq
            assign rd_o[b] = lvl_i[b-IRQ_BIT_LO];
        end else if (b < IRQ_BIT_LO) begin : g_low
            assign rd_o[b] = data_i[b];
        end else begin : g_high
            assign rd_o[b] = data_i[b-NUM_LINES];
        end
    end

endmodule

// File: rtl/irq_accept_unit.sv
module irq_accept_unit #(
    parameter int NUM_LINES   = 2,
    parameter int SYNC_STAGES = 2,
    parameter int PORT_W      = 8,
    parameter int IRQ_BIT_LO  = 4,
    localparam int LINE_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_LINES-1:0]        irq_pin_i,
    input  logic [NUM_LINES-1:0]        edge_rise_i,
    input  logic                        irq_en_i,
    input  logic [PORT_W-NUM_LINES-1:0] port_data_i,
    output logic [PORT_W-1:0]           port_rd_o,
    input  logic                        instr_done_i,
    input  logic                        instr_priv_i,
    input  logic [NUM_LINES-1:0]        ack_i,
    output logic                        take_o,
    output logic [LINE_W-1:0]           take_line_o
);

    logic [NUM_LINES-1:0] lvl_vec;
    logic [NUM_LINES-1:0] pend_vec;

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        irq_line_detect #(
            .SYNC_STAGES(SYNC_STAGES)
        ) u_det (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_i     (irq_pin_i[i]),
            .rise_sel_i(edge_rise_i[i]),
            .ack_i     (ack_i[i]),
            .level_o   (lvl_vec[i]),
            .pend_o    (pend_vec[i])
        );
    end

    irq_accept_arb #(
        .NUM_LINES(NUM_LINES),
        .LINE_W   (LINE_W)
    ) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .pend_i(pend_vec),
        .en_i  (irq_en_i),
        .done_i(instr_done_i),
        .priv_i(instr_priv_i),
        .take_o(take_o),
        .line_o(take_line_o)
    );

    irq_port_merge #(
        .NUM_LINES (NUM_LINES),
        .PORT_W    (PORT_W),
        .IRQ_BIT_LO(IRQ_BIT_LO)
    ) u_port (
        .lvl_i (lvl_vec),
        .data_i(port_data_i),
        .rd_o  (port_rd_o)
    );

    assert_offered_line_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> pend_vec[take_line_o]);

    assert_port_tracks_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
        port_rd_o[IRQ_BIT_LO +: NUM_LINES] == lvl_vec);

endmodule

// File: tb/irq_accept_unit_test.sv
`timescale 1ns/1ps
module irq_accept_unit_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] irq_pin_i = '0;
    logic [1:0] edge_rise_i = 2'b11;
    logic       irq_en_i = 1'b1;
    logic [5:0] port_data_i = '0;
    logic [7:0] port_rd_o;
    logic       instr_done_i = 1'b0;
    logic       instr_priv_i = 1'b0;
    logic [1:0] ack_i = '0;
    logic       take_o;
    logic [0:0] take_line_o;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic  take;
        logic  line;
        string tag;
    } exp_t;
    exp_t sbq[$];

    always #2.5 clk = ~clk;

    irq_accept_unit uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_pin_i   (irq_pin_i),
        .edge_rise_i (edge_rise_i),
        .irq_en_i    (irq_en_i),
        .port_data_i (port_data_i),
        .port_rd_o   (port_rd_o),
        .instr_done_i(instr_done_i),
        .instr_priv_i(instr_priv_i),
        .ack_i       (ack_i),
        .take_o      (take_o),
        .take_line_o (take_line_o)
    );

    // monitor: compare offer at each completion strobe
    always @(negedge clk) begin
        if (rst_n && instr_done_i) begin
            checks++;
            if (sbq.size() == 0) begin
                fails++;
                $display("FAIL scoreboard: unexpected boundary, take=%0b", take_o);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                if (take_o !== e.take || (e.take && take_line_o[0] !== e.line)) begin
                    fails++;
                    $display("FAIL %s: take=%0b line=%0d, expected take=%0b line=%0d",
                             e.tag, take_o, take_line_o, e.take, e.line);
                end
            end
        end
    end

    task automatic boundary(input logic priv, input logic exp_take,
                            input logic exp_line, input string tag);
        exp_t e;
        @(posedge clk); #1;
        instr_done_i = 1'b1;
        instr_priv_i = priv;
        e.take = exp_take; e.line = exp_line; e.tag = tag;
        sbq.push_back(e);
        @(posedge clk); #1;
        instr_done_i = 1'b0;
        instr_priv_i = 1'b0;
    endtask

    task automatic set_pin(input int l, input logic v);
        @(posedge clk); #1;
        irq_pin_i[l] = v;
        repeat (4) @(posedge clk);
    endtask

    task automatic ack_line(input int l);
        @(posedge clk); #1;
        ack_i[l] = 1'b1;
        @(posedge clk); #1;
        ack_i = '0;
    endtask

    task automatic check_port(input logic [7:0] exp, input string tag);
        @(negedge clk);
        checks++;
        if (port_rd_o !== exp) begin
            fails++;
            $display("FAIL %s: port_rd=%h expected %h", tag, port_rd_o, exp);
        end
    endtask

    task automatic check_idle(input string tag);
        @(negedge clk);
        checks++;
        if (take_o !== 1'b0) begin
            fails++;
            $display("FAIL %s: take=%0b expected 0", tag, take_o);
        end
    endtask

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog: run hung, take=%0b expected finish", take_o);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk); #1;
        rst_n = 1'b1;
        // R10: clean state after reset
        check_idle("R10 reset idle");
        check_port(8'h00, "R3 reset port");
        boundary(1'b0, 1'b0, 1'b0, "R10 nothing pending after reset");

        // R1 / R5: rising edge on line 0
        set_pin(0, 1'b1);
        check_idle("R5 no take without strobe");
        boundary(1'b0, 1'b1, 1'b0, "R1 line0 rising taken");
        ack_line(0);
        boundary(1'b0, 1'b0, 1'b0, "R7 ack cleared line0");

        // R3: port word layout
        port_data_i = 6'b10_1101;
        check_port(8'b1001_1101, "R3 port low/high pass-through, bit4 level");
        set_pin(1, 1'b1);
        check_port(8'b1011_1101, "R3 bit5 line1 level");
        boundary(1'b0, 1'b1, 1'b1, "R1 line1 rising taken");
        ack_line(1);

        // R6: privileged chain defers
        set_pin(0, 1'b0);
        set_pin(1, 1'b0);
        set_pin(0, 1'b1);
        boundary(1'b1, 1'b0, 1'b0, "R6 privileged completion defers");
        boundary(1'b1, 1'b0, 1'b0, "R6 privileged chain still defers");
        boundary(1'b0, 1'b1, 1'b0, "R6 non-privileged completion takes");
        ack_line(0);

        // R8: both pending
        set_pin(0, 1'b0);
        @(posedge clk); #1;
        irq_pin_i = 2'b11;
        repeat (4) @(posedge clk);
        boundary(1'b0, 1'b1, 1'b0, "R8 line0 first");
        ack_line(0);
        boundary(1'b0, 1'b1, 1'b1, "R8 line1 held then offered");
        ack_line(1);
        boundary(1'b0, 1'b0, 1'b0, "R8 both cleared");

        // R4: repeated edges collapse
        set_pin(0, 1'b0);
        set_pin(0, 1'b1);
        set_pin(0, 1'b0);
        set_pin(0, 1'b1);
        set_pin(0, 1'b0);
        set_pin(0, 1'b1);
        boundary(1'b0, 1'b1, 1'b0, "R4 one request for many edges");
        ack_line(0);
        boundary(1'b0, 1'b0, 1'b0, "R4 nothing after single ack");

        // R2: line1 falling-edge selection
        edge_rise_i = 2'b01;
        set_pin(1, 1'b0);
        boundary(1'b0, 1'b1, 1'b1, "R2 line1 falling taken");
        ack_line(1);
        set_pin(1, 1'b1);
        boundary(1'b0, 1'b0, 1'b0, "R2 rising ignored on falling line");

        // R7: edge coinciding with ack wins
        set_pin(0, 1'b0);
        set_pin(0, 1'b1);
        set_pin(0, 1'b0);
        @(posedge clk); #1;
        irq_pin_i[0] = 1'b1;
        @(posedge clk);
        @(posedge clk); #1;
        ack_i[0] = 1'b1;
        @(posedge clk); #1;
        ack_i = '0;
        repeat (2) @(posedge clk);
        boundary(1'b0, 1'b1, 1'b0, "R7 edge wins over ack");
        ack_line(0);
        boundary(1'b0, 1'b0, 1'b0, "R7 plain ack clears");

        // R9: enable gates offer, latching continues
        set_pin(0, 1'b0);
        irq_en_i = 1'b0;
        set_pin(0, 1'b1);
        boundary(1'b0, 1'b0, 1'b0, "R9 disabled no take");
        check_port(8'b1011_1101, "R3 levels visible while disabled");
        boundary(1'b0, 1'b0, 1'b0, "R9 still disabled");
        irq_en_i = 1'b1;
        boundary(1'b0, 1'b1, 1'b0, "R9 latched request taken after enable");
        ack_line(0);

        // R10: reset drops a pending request
        edge_rise_i = 2'b11;
        set_pin(1, 1'b0);
        set_pin(0, 1'b0);
        set_pin(0, 1'b1);
        set_pin(0, 1'b0);
        @(posedge clk); #1;
        rst_n = 1'b0;
        repeat (2) @(posedge clk); #1;
        rst_n = 1'b1;
        repeat (3) @(posedge clk);
        boundary(1'b0, 1'b0, 1'b0, "R10 pending cleared by reset");

        repeat (2) @(posedge clk);
        if (sbq.size() != 0) begin
            fails++;
            $display("FAIL scoreboard: %0d items left, expected 0", sbq.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule